// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves the control-transfer instructions of a 64-bit register machine. Each cycle it may accept one decoded jump-class instruction: opcode, source-select bit, class, both register operands, the 32-bit immediate, the 16-bit offset and the address of the following instruction. One clock later it reports whether control transfers and the resulting program counter.

Two classes are recognised. Class 5 compares full 64-bit operands. Class 6 compares only the low 32 bits of each operand. The second operand is either the source register or the sign-extended immediate. Displacements count instructions of 8 bytes each. Call and exit instructions are only flagged here, because another stage handles them. Undefined encodings raise an illegal flag. Any instruction outside the two jump classes yields a plain fall-through.

Top module: `branch_resolve_unit`

## Requirements
- R1: While reset is active, and on the first sample after it, out_valid, taken, all flags and target are zero.
- R2: out_valid equals in_valid delayed by exactly one clock. Results appear on the cycle after the inputs are presented.
- R3: Opcode 1 takes when the operands are equal. Opcode 5 takes when they differ. Opcode 4 takes when their bitwise AND is non-zero.
- R4: The unsigned orderings take when their condition holds: 2 (greater), 3 (greater or equal), 0xa (less), 0xb (less or equal).
- R5: The signed two's-complement orderings take when their condition holds: 6 (greater), 7 (greater or equal), 0xc (less), 0xd (less or equal).
- R6: In class 6 only bits 31:0 of both operands take part in the comparison. Signed kinds use bit 31 as the sign.
- R7: With src_sel = 1 the second operand is src_val. With src_sel = 0 it is the 32-bit immediate, sign-extended to 64 bits.
- R8: A taken class-5 jump, and every taken conditional jump, has target = next_pc + sign-extended offset × 8, modulo 2^64.
- R9: Opcode 0 always takes. In class 5 its displacement is the offset. In class 6 it is the signed 32-bit immediate × 8.
- R10: When a jump is not taken, taken is 0 and target equals next_pc.
- R11: Opcode 8 in class 5 raises is_call, and also call_indirect when src_sel = 1. Opcode 9 in class 5 raises is_exit. Neither one is taken.
- R12: Opcodes 0xe and 0xf in either jump class, and opcodes 8 and 9 in class 6, raise illegal. They are not taken and raise no other flag.
- R13: A class other than 5 or 6 raises no flag and is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 4 | Operation field |
| src_sel | input | 1 | 1: register second operand, 0: immediate |
| cls | input | 3 | Instruction class |
| dst_val | input | 64 | First operand |
| src_val | input | 64 | Register second operand |
| imm | input | 32 | Immediate |
| offset | input | 16 | Signed instruction displacement |
| next_pc | input | 64 | Address of the following instruction |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Control transfers to target |
| target | output | 64 | Next program counter |
| is_call | output | 1 | Call instruction seen |
| call_indirect | output | 1 | Call target comes from a register |
| is_exit | output | 1 | Exit instruction seen |
| illegal | output | 1 | Undefined jump-class encoding |

## Verification
On every cycle the assertions check the following:
- The one-cycle valid latency.
- That taken, call, exit and illegal are mutually exclusive.
- That an indirect call is always a call.
- That a fall-through target equals the presented next_pc.
- That a taken target keeps the 8-byte alignment of next_pc.

Only the bench scenarios can show the rest:
- Which comparison each opcode performs.
- The 32-bit truncation and its sign handling.
- Sign extension of the immediate.
- The exact displacement source and scaling, including wrap-around below zero.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int XLEN       = 64;
  localparam int NARROW     = 32;
  localparam int IMM_W      = 32;
  localparam int OFF_W      = 16;
  localparam int INSN_BYTES = 8;
  localparam int SCALE_SH   = $clog2(INSN_BYTES);
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  typedef enum logic [3:0] {
    K_NEVER, K_ALWAYS, K_EQ, K_NE, K_SET,
    K_UGT, K_UGE, K_ULT, K_ULE,
    K_SGT, K_SGE, K_SLT, K_SLE
  } cond_kind_e;

  function automatic logic [XLEN-1:0] sx_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sx_off(input logic [OFF_W-1:0] v);
    return {{(XLEN-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] scale(input logic [XLEN-1:0] d);
    return d << SCALE_SH;
  endfunction
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [3:0]  opcode,
  input  logic        src_sel,
  input  logic [2:0]  cls,
  output cond_kind_e  kind,
  output logic        imm_disp,
  output logic        call_f,
  output logic        call_ind_f,
  output logic        exit_f,
  output logic        bad_f
);
  logic wide, narrow;
  assign wide   = (cls == CLS_WIDE);
  assign narrow = (cls == CLS_NARROW);

  always_comb begin
    kind       = K_NEVER;
    imm_disp   = 1'b0;
    call_f     = 1'b0;
    call_ind_f = 1'b0;
    exit_f     = 1'b0;
    bad_f      = 1'b0;
    if (wide || narrow) begin
      case (opcode)
        4'h0: begin kind = K_ALWAYS; imm_disp = narrow; end
        4'h1: kind = K_EQ;
        4'h2: kind = K_UGT;
        4'h3: kind = K_UGE;
        4'h4: kind = K_SET;
        4'h5: kind = K_NE;
        4'h6: kind = K_SGT;
        4'h7: kind = K_SGE;
        4'h8: begin
          call_f     = wide;
          call_ind_f = wide & src_sel;
          bad_f      = narrow;
        end
        4'h9: begin exit_f = wide; bad_f = narrow; end
        4'ha: kind = K_ULT;
        4'hb: kind = K_ULE;
        4'hc: kind = K_SLT;
        4'hd: kind = K_SLE;
        default: bad_f = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bru_compare.sv
module bru_compare
  import bru_pkg::*;
(
  input  cond_kind_e       kind,
  input  logic             is_narrow,
  input  logic [XLEN-1:0]  lhs,
  input  logic [XLEN-1:0]  rhs,
  output logic             hit
);
  logic [XLEN-1:0] lu, ru;
  logic signed [XLEN-1:0] ls, rs;

  always_comb begin
    if (is_narrow) begin
      lu = {{(XLEN-NARROW){1'b0}}, lhs[NARROW-1:0]};
      ru = {{(XLEN-NARROW){1'b0}}, rhs[NARROW-1:0]};
      ls = {{(XLEN-NARROW){lhs[NARROW-1]}}, lhs[NARROW-1:0]};
      rs = {{(XLEN-NARROW){rhs[NARROW-1]}}, rhs[NARROW-1:0]};
    end else begin
      lu = lhs;
      ru = rhs;
      ls = lhs;
      rs = rhs;
    end
  end

  always_comb begin
    case (kind)
      K_ALWAYS: hit = 1'b1;
      K_EQ:     hit = (lu == ru);
      K_NE:     hit = (lu != ru);
      K_SET:    hit = |(lu & ru);
      K_UGT:    hit = (lu >  ru);
      K_UGE:    hit = (lu >= ru);
      K_ULT:    hit = (lu <  ru);
      K_ULE:    hit = (lu <= ru);
      K_SGT:    hit = (ls >  rs);
      K_SGE:    hit = (ls >= rs);
      K_SLT:    hit = (ls <  rs);
      K_SLE:    hit = (ls <= rs);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
(
  input  logic [XLEN-1:0]  next_pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [OFF_W-1:0] offset,
  input  logic             imm_disp,
  input  logic             take,
  output logic [XLEN-1:0]  dest
);
  logic [XLEN-1:0] disp;
  assign disp = imm_disp ? sx_imm(imm) : sx_off(offset);
  assign dest = take ? (next_pc + scale(disp)) : next_pc;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic              src_sel,
  input  logic [2:0]        cls,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [OFF_W-1:0]  offset,
  input  logic [XLEN-1:0]   next_pc,
  output logic              out_valid,
  output logic              taken,
  output logic [XLEN-1:0]   target,
  output logic              is_call,
  output logic              call_indirect,
  output logic              is_exit,
  output logic              illegal
);
  cond_kind_e      kind_w;
  logic            imm_disp_w, call_w, call_ind_w, exit_w, bad_w;
  logic            hit_w;
  logic [XLEN-1:0] rhs_w, dest_w;

  bru_decode u_dec (
    .opcode(opcode), .src_sel(src_sel), .cls(cls),
    .kind(kind_w), .imm_disp(imm_disp_w), .call_f(call_w),
    .call_ind_f(call_ind_w), .exit_f(exit_w), .bad_f(bad_w)
  );

  assign rhs_w = src_sel ? src_val : sx_imm(imm);

  bru_compare u_cmp (
    .kind(kind_w), .is_narrow(cls == CLS_NARROW),
    .lhs(dst_val), .rhs(rhs_w), .hit(hit_w)
  );

  bru_target u_tgt (
    .next_pc(next_pc), .imm(imm), .offset(offset),
    .imm_disp(imm_disp_w), .take(hit_w), .dest(dest_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      taken         <= 1'b0;
      target        <= '0;
      is_call       <= 1'b0;
      call_indirect <= 1'b0;
      is_exit       <= 1'b0;
      illegal       <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      taken         <= hit_w;
      target        <= dest_w;
      is_call       <= call_w;
      call_indirect <= call_ind_w;
      is_exit       <= exit_w;
      illegal       <= bad_w;
    end
  end

  // R2: one-cycle valid latency
  a_r2_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_lat: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: fall-through target is the presented next address
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || target == $past(next_pc)));
  // R8: taken target keeps instruction alignment of next_pc
  a_r8_align: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!taken || target[SCALE_SH-1:0] == $past(next_pc[SCALE_SH-1:0])));
  // R12: outcome flags are mutually exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, is_call, is_exit, illegal}));
  // R11: indirect implies call
  a_r11_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    call_indirect |-> is_call);
endmodule

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic        src_sel = 1'b0;
  logic [2:0]  cls = '0;
  logic [63:0] dst_val = '0, src_val = '0, next_pc = '0;
  logic [31:0] imm = '0;
  logic [15:0] offset = '0;
  logic        out_valid, taken, is_call, call_indirect, is_exit, illegal;
  logic [63:0] target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  branch_resolve_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_sel(src_sel), .cls(cls), .dst_val(dst_val), .src_val(src_val),
    .imm(imm), .offset(offset), .next_pc(next_pc), .out_valid(out_valid),
    .taken(taken), .target(target), .is_call(is_call),
    .call_indirect(call_indirect), .is_exit(is_exit), .illegal(illegal)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic        sel;
    logic [2:0]  cl;
    logic [63:0] dv;
    logic [63:0] sv;
    logic [31:0] im;
    logic [15:0] of;
    logic [63:0] np;
    logic        tk;
    logic [63:0] tg;
    logic [3:0]  fl;   // {call, indirect, exit, illegal}
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    // R3 equality / inequality / bit-test
    '{8'd3, 4'h1, 1'b1, 3'd5, 64'd5, 64'd5, 32'd0, 16'd4, 64'h1000, 1'b1, 64'h1020, 4'h0},
    '{8'd3, 4'h1, 1'b1, 3'd5, 64'd5, 64'd6, 32'd0, 16'd4, 64'h1000, 1'b0, 64'h1000, 4'h0},
    '{8'd3, 4'h5, 1'b1, 3'd5, 64'd5, 64'd6, 32'd0, 16'd2, 64'h1000, 1'b1, 64'h1010, 4'h0},
    '{8'd3, 4'h4, 1'b1, 3'd5, 64'hF0, 64'h10, 32'd0, 16'hFFFE, 64'h1000, 1'b1, 64'h0FF0, 4'h0},
    '{8'd3, 4'h4, 1'b1, 3'd5, 64'hF0, 64'h0F, 32'd0, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    // R7 immediate operand, R3 not-equal with equal values
    '{8'd7, 4'h5, 1'b0, 3'd5, 64'd7, 64'd9, 32'd7, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    // R4 unsigned orderings
    '{8'd4, 4'h2, 1'b1, 3'd5, 64'hFFFFFFFFFFFFFFFF, 64'd1, 32'd0, 16'd1, 64'h1000, 1'b1, 64'h1008, 4'h0},
    '{8'd4, 4'ha, 1'b1, 3'd5, 64'd3, 64'd3, 32'd0, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    '{8'd4, 4'hb, 1'b1, 3'd5, 64'd3, 64'd3, 32'd0, 16'd1, 64'h1000, 1'b1, 64'h1008, 4'h0},
    '{8'd4, 4'h3, 1'b1, 3'd5, 64'd3, 64'd3, 32'd0, 16'd3, 64'h1000, 1'b1, 64'h1018, 4'h0},
    // R5 signed orderings
    '{8'd5, 4'h6, 1'b1, 3'd5, 64'hFFFFFFFFFFFFFFFF, 64'd1, 32'd0, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    '{8'd5, 4'hc, 1'b1, 3'd5, 64'hFFFFFFFFFFFFFFFF, 64'd1, 32'd0, 16'd3, 64'h1000, 1'b1, 64'h1018, 4'h0},
    '{8'd5, 4'h7, 1'b1, 3'd5, 64'd2, 64'd2, 32'd0, 16'd1, 64'h1000, 1'b1, 64'h1008, 4'h0},
    // R6 narrow class: low 32 bits only
    '{8'd6, 4'h3, 1'b1, 3'd6, 64'hFFFFFFFF00000002, 64'h0000000100000003, 32'd0, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    '{8'd6, 4'h7, 1'b1, 3'd6, 64'h0000000080000000, 64'd0, 32'd0, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    '{8'd6, 4'hd, 1'b1, 3'd6, 64'h0000000080000000, 64'd0, 32'd0, 16'd2, 64'h1000, 1'b1, 64'h1010, 4'h0},
    // R7 immediate sign extension
    '{8'd7, 4'h2, 1'b0, 3'd5, 64'h0000000100000000, 64'd0, 32'hFFFFFFFF, 16'd1, 64'h1000, 1'b0, 64'h1000, 4'h0},
    // R8 / R9 unconditional displacement sources, R8 wrap
    '{8'd8, 4'h0, 1'b0, 3'd5, 64'd0, 64'd0, 32'd100, 16'hFFFF, 64'h1000, 1'b1, 64'h0FF8, 4'h0},
    '{8'd9, 4'h0, 1'b0, 3'd6, 64'd0, 64'd0, 32'hFFFFFFFE, 16'd5, 64'h1000, 1'b1, 64'h0FF0, 4'h0},
    '{8'd9, 4'h0, 1'b0, 3'd6, 64'd0, 64'd0, 32'h10, 16'd5, 64'h1000, 1'b1, 64'h1080, 4'h0},
    '{8'd8, 4'h1, 1'b1, 3'd5, 64'd1, 64'd1, 32'd0, 16'hFFFE, 64'h8, 1'b1, 64'hFFFFFFFFFFFFFFF8, 4'h0},
    // R11 call / exit
    '{8'd11, 4'h8, 1'b0, 3'd5, 64'd0, 64'd0, 32'd7, 16'd0, 64'h2000, 1'b0, 64'h2000, 4'b1000},
    '{8'd11, 4'h8, 1'b1, 3'd5, 64'd0, 64'd0, 32'd0, 16'd0, 64'h2000, 1'b0, 64'h2000, 4'b1100},
    '{8'd11, 4'h9, 1'b0, 3'd5, 64'd0, 64'd0, 32'd0, 16'd0, 64'h2000, 1'b0, 64'h2000, 4'b0010},
    // R12 illegal encodings
    '{8'd12, 4'he, 1'b1, 3'd5, 64'd1, 64'd1, 32'd0, 16'd1, 64'h3000, 1'b0, 64'h3000, 4'b0001},
    '{8'd12, 4'h8, 1'b1, 3'd6, 64'd1, 64'd1, 32'd0, 16'd1, 64'h3000, 1'b0, 64'h3000, 4'b0001}
  };

  task automatic fail_line(input string req, input logic [127:0] act, input logic [127:0] exp);
    fails++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) fail_line(req, act, exp);
  endtask

  task automatic drive(input logic [3:0] o, input logic s, input logic [2:0] c,
                       input logic [63:0] d, input logic [63:0] sv,
                       input logic [31:0] i, input logic [15:0] f, input logic [63:0] n);
    @(negedge clk);
    in_valid = 1'b1; opcode = o; src_sel = s; cls = c;
    dst_val = d; src_val = sv; imm = i; offset = f; next_pc = n;
    @(negedge clk);
  endtask

  function automatic logic [127:0] pack_out();
    return {56'd0, out_valid, taken, target, is_call, call_indirect, is_exit, illegal};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fail_line("watchdog", 128'd0, 128'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", pack_out(), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", pack_out(), 128'd0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].op, VECS[k].sel, VECS[k].cl, VECS[k].dv, VECS[k].sv,
            VECS[k].im, VECS[k].of, VECS[k].np);
      checks++;
      if (pack_out() !== {56'd0, 1'b1, VECS[k].tk, VECS[k].tg, VECS[k].fl})
        fail_line($sformatf("R%0d vector %0d", VECS[k].req, k), pack_out(),
                  {56'd0, 1'b1, VECS[k].tk, VECS[k].tg, VECS[k].fl});
    end

    // R12 opcode 0xf, opcode 9 narrow
    drive(4'hf, 1'b0, 3'd6, 64'd0, 64'd0, 32'd0, 16'd3, 64'h40);
    check("R12 op f", pack_out(), {56'd0, 1'b1, 1'b0, 64'h40, 4'b0001});
    drive(4'h9, 1'b0, 3'd6, 64'd0, 64'd0, 32'd0, 16'd3, 64'h40);
    check("R12 exit narrow", pack_out(), {56'd0, 1'b1, 1'b0, 64'h40, 4'b0001});
    // R13 non-jump class with equal operands and opcode 0
    drive(4'h1, 1'b1, 3'd3, 64'd4, 64'd4, 32'd0, 16'd3, 64'h500);
    check("R13 other class", pack_out(), {56'd0, 1'b1, 1'b0, 64'h500, 4'b0000});
    drive(4'h0, 1'b0, 3'd7, 64'd0, 64'd0, 32'd9, 16'd3, 64'h500);
    check("R13 other class op0", pack_out(), {56'd0, 1'b1, 1'b0, 64'h500, 4'b0000});
    // R10 fall-through from a different next_pc
    drive(4'h6, 1'b0, 3'd5, 64'd1, 64'd0, 32'd5, 16'd9, 64'hABC8);
    check("R10 not taken", pack_out(), {56'd0, 1'b1, 1'b0, 64'hABC8, 4'b0000});

    // R2 idle after valid
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle", {127'd0, out_valid}, 128'd0);

    // R1 reset in the middle of activity
    in_valid = 1'b1; opcode = 4'h0; cls = 3'd5; offset = 16'd1; next_pc = 64'h100;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", pack_out(), 128'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule